// File: doc/BRIEF.md
# Inter-Peer Doorbell Register Block

This block is the small register window of a shared-memory messaging device that links several nodes. Software on the local node sees three storage registers: an interrupt mask, an interrupt status that empties itself when read, and a read-only identifier giving this node's position among the peers. It also sees a doorbell register. Writing the doorbell packs a destination peer and a vector number into one word. The block checks the word against the peer count and against that peer's own vector count. It issues a one-cycle notification toward the peer only when both checks pass.

Notifications from other peers arrive as one-cycle pulses, one per local vector. In legacy mode any such pulse loads the status register with the value 1, and a level interrupt line follows the masked status. In message-interrupt mode each vector has its own interrupt request pulse. A vector that is masked when its event arrives keeps a pending bit, and that bit is delivered once when the vector is unmasked.

Top module: `peer_doorbell_regs`

## Requirements
- R1: After reset the mask and status registers read as zero, no doorbell or message-interrupt pulse is issued, no pending bit is set and the legacy line is low.
- R2: A write to the mask register (offset 0x00) or the status register (offset 0x04) stores all 32 data bits. The write address is ANDed with 0xFC before decoding, so address 0x05 writes the status register.
- R3: Every read is answered one cycle later with `rsp_valid` high. Offset 0x00 returns the mask, 0x04 the status, and 0x08 the zero-extended node identifier. Reads are decoded on the full address, and any other address, including the doorbell at 0x0C and unaligned addresses, returns zero.
- R4: A status read returns the value held before the access and leaves the status register at zero.
- R5: A doorbell write (offset 0x0C) takes the destination peer from data bits 31:16 and the vector from bits 7:0, ignores bits 15:8, and raises `bell_fire` for exactly the one cycle after the write, with the peer and vector on `bell_peer` and `bell_vector`. No other write raises `bell_fire`.
- R6: A doorbell write whose destination is not below `peer_count`, or not below the number of table entries, is dropped.
- R7: A doorbell write whose vector is not below the destination peer's entry in `peer_vec_counts` is dropped. Entry i occupies bits [8*i+7:8*i].
- R8: In legacy mode (`msg_mode` = 0), an event on any local vector sets the status register to 1. This takes precedence over a same-cycle status write or read-clear.
- R9: `legacy_irq` is high exactly while the bitwise AND of status and mask is nonzero.
- R10: In message-interrupt mode with `msg_enable` high, an event on an unmasked vector raises that vector's `msg_irq` bit for one cycle, one cycle after the event.
- R11: In message-interrupt mode with `msg_enable` high, an event on a masked vector sets that vector's `msg_pending` bit and raises no `msg_irq`.
- R12: When a vector with its pending bit set becomes unmasked while message interrupts are enabled, its `msg_irq` bit pulses once and the pending bit clears.
- R13: In message-interrupt mode with `msg_enable` low, events are dropped. They produce no `msg_irq`, no pending bit and no change to the status register.
- R14: Writes to undecoded offsets, and to the identifier at 0x08, change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset in the 256-byte window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle after a read) |
| rsp_rdata | output | 32 | Read data |
| own_id | input | 16 | This node's position among the peers |
| peer_count | input | 16 | Number of peers currently known |
| peer_vec_counts | input | NUM_PEERS*8 | Registered vector count per peer |
| msg_mode | input | 1 | 0 = legacy status interrupt, 1 = per-vector message interrupts |
| msg_enable | input | 1 | Message interrupts enabled |
| vec_mask | input | NUM_VECS | Per-vector message-interrupt mask |
| local_event | input | NUM_VECS | Incoming event pulse per local vector |
| bell_fire | output | 1 | One-cycle doorbell notification |
| bell_peer | output | 16 | Destination peer of the notification |
| bell_vector | output | 8 | Destination vector of the notification |
| legacy_irq | output | 1 | Level interrupt in legacy mode |
| msg_irq | output | NUM_VECS | Per-vector message-interrupt pulse |
| msg_pending | output | NUM_VECS | Per-vector pending bit |

## Verification
Two functions can hit the status register on the same clock edge: a software access to it, either a read-clear or a full write, and an incoming legacy event that loads it with 1. The bench preloads the status with a known pattern. It then drives a status read and an event pulse in the same cycle, and checks that the read returns the old pattern while a following read returns 1. It repeats this with a status write in place of the read. The message-interrupt side gets the same treatment: an unmask is applied while a pending bit is held, and the bench checks that exactly one pulse results.

// File: rtl/ivdb_pkg.sv
package ivdb_pkg;

    localparam int REG_W       = 32;
    localparam int ADDR_W      = 8;
    localparam int BELL_PEER_W = 16;
    localparam int BELL_VEC_W  = 8;
    localparam int ID_W        = 16;

    localparam logic [ADDR_W-1:0] WR_ALIGN = 8'hFC;
    localparam logic [ADDR_W-1:0] OFF_MASK = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_STAT = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_ID   = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_BELL = 8'h0C;

    typedef enum logic [2:0] {
        SEL_MASK,
        SEL_STAT,
        SEL_ID,
        SEL_BELL,
        SEL_NONE
    } reg_sel_e;

    // Doorbell data word layout; the middle byte carries nothing.
    typedef struct packed {
        logic [BELL_PEER_W-1:0] peer;
        logic [7:0]             spare;
        logic [BELL_VEC_W-1:0]  vector;
    } bell_word_t;

    function automatic reg_sel_e decode_off(input logic [ADDR_W-1:0] off);
        reg_sel_e sel;
        case (off)
            OFF_MASK: sel = SEL_MASK;
            OFF_STAT: sel = SEL_STAT;
            OFF_ID:   sel = SEL_ID;
            OFF_BELL: sel = SEL_BELL;
            default:  sel = SEL_NONE;
        endcase
        return sel;
    endfunction

    function automatic logic [ADDR_W-1:0] write_offset(input logic [ADDR_W-1:0] a);
        return a & WR_ALIGN;
    endfunction

endpackage

// File: rtl/ivdb_regfile.sv
module ivdb_regfile
    import ivdb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  reg_sel_e         wr_sel,
    input  logic [REG_W-1:0] wdata,
    input  logic             rd_en,
    input  reg_sel_e         rd_sel,
    input  logic [ID_W-1:0]  own_id,
    input  logic             legacy_hit,
    output logic [REG_W-1:0] mask_q,
    output logic [REG_W-1:0] stat_q,
    output logic             rsp_valid,
    output logic [REG_W-1:0] rsp_rdata
);

    logic [REG_W-1:0] mask_n;
    logic [REG_W-1:0] stat_n;
    logic [REG_W-1:0] rd_mux;

    always_comb begin
        mask_n = mask_q;
        stat_n = stat_q;
        if (wr_en && wr_sel == SEL_MASK) mask_n = wdata;
        if (wr_en && wr_sel == SEL_STAT) stat_n = wdata;
        if (rd_en && rd_sel == SEL_STAT) stat_n = '0;
        // An incoming legacy event outranks any software access.
        if (legacy_hit) stat_n = REG_W'(1);
    end

    always_comb begin
        case (rd_sel)
            SEL_MASK: rd_mux = mask_q;
            SEL_STAT: rd_mux = stat_q;
            SEL_ID:   rd_mux = REG_W'(own_id);
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q    <= '0;
            stat_q    <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            mask_q    <= mask_n;
            stat_q    <= stat_n;
            rsp_valid <= rd_en;
            rsp_rdata <= rd_en ? rd_mux : '0;
        end
    end

    AST_STAT_RDCLR: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_sel == SEL_STAT && !legacy_hit && !(wr_en && wr_sel == SEL_STAT))
        |=> (stat_q == '0)); // R4

    AST_LEGACY_LOAD: assert property (@(posedge clk) disable iff (rst)
        legacy_hit |=> (stat_q == REG_W'(1))); // R8

    AST_RSP_FOLLOWS_RD: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rsp_valid); // R3

endmodule

// File: rtl/ivdb_doorbell.sv
module ivdb_doorbell
    import ivdb_pkg::*;
#(
    parameter int NUM_PEERS = 4
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            bell_wr,
    input  bell_word_t                      bell_word,
    input  logic [BELL_PEER_W-1:0]          peer_count,
    input  logic [NUM_PEERS*BELL_VEC_W-1:0] peer_vec_counts,
    output logic                            fire_q,
    output logic [BELL_PEER_W-1:0]          peer_q,
    output logic [BELL_VEC_W-1:0]           vector_q
);

    logic [BELL_VEC_W-1:0] cnt_tab [NUM_PEERS];
    logic [BELL_VEC_W-1:0] sel_cnt;
    logic                  in_table;
    logic                  peer_ok;
    logic                  vec_ok;
    logic                  accept;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_PEERS; gi++) begin : g_tab
            assign cnt_tab[gi] = peer_vec_counts[gi*BELL_VEC_W +: BELL_VEC_W];
        end
    endgenerate

    always_comb begin
        sel_cnt  = '0;
        in_table = 1'b0;
        for (int i = 0; i < NUM_PEERS; i++) begin
            if (bell_word.peer == BELL_PEER_W'(i)) begin
                sel_cnt  = cnt_tab[i];
                in_table = 1'b1;
            end
        end
    end

    assign peer_ok = in_table && (bell_word.peer < peer_count);
    assign vec_ok  = bell_word.vector < sel_cnt;
    assign accept  = bell_wr && peer_ok && vec_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            fire_q   <= 1'b0;
            peer_q   <= '0;
            vector_q <= '0;
        end else begin
            fire_q <= accept;
            if (accept) begin
                peer_q   <= bell_word.peer;
                vector_q <= bell_word.vector;
            end
        end
    end

    AST_FIRE_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        fire_q |-> $past(bell_wr)); // R5

    AST_PEER_BOUND: assert property (@(posedge clk) disable iff (rst)
        fire_q |-> (peer_q < $past(peer_count))); // R6

    AST_VEC_BOUND: assert property (@(posedge clk) disable iff (rst)
        fire_q |-> (vector_q < $past(sel_cnt))); // R7

endmodule

// File: rtl/ivdb_vec_slot.sv
module ivdb_vec_slot (
    input  logic clk,
    input  logic rst,
    input  logic evt,
    input  logic masked,
    input  logic route_on,
    output logic irq_q,
    output logic pend_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q  <= 1'b0;
            pend_q <= 1'b0;
        end else if (route_on) begin
            // Deliver when unmasked: a new event, or one held while masked.
            irq_q  <= !masked && (evt || pend_q);
            pend_q <= masked && (evt || pend_q);
        end else begin
            irq_q <= 1'b0;
        end
    end

    AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> !$past(masked)); // R11

    AST_UNMASK_DELIVER: assert property (@(posedge clk) disable iff (rst)
        ($fell(masked) && pend_q && route_on) |=> (irq_q && !pend_q)); // R12

    AST_ROUTE_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        !route_on |=> !irq_q); // R13

endmodule

// File: rtl/peer_doorbell_regs.sv
module peer_doorbell_regs
    import ivdb_pkg::*;
#(
    parameter int NUM_PEERS = 4,
    parameter int NUM_VECS  = 4
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            req_valid,
    input  logic                            req_write,
    input  logic [ADDR_W-1:0]               req_addr,
    input  logic [REG_W-1:0]                req_wdata,
    output logic                            rsp_valid,
    output logic [REG_W-1:0]                rsp_rdata,
    input  logic [ID_W-1:0]                 own_id,
    input  logic [BELL_PEER_W-1:0]          peer_count,
    input  logic [NUM_PEERS*BELL_VEC_W-1:0] peer_vec_counts,
    input  logic                            msg_mode,
    input  logic                            msg_enable,
    input  logic [NUM_VECS-1:0]             vec_mask,
    input  logic [NUM_VECS-1:0]             local_event,
    output logic                            bell_fire,
    output logic [BELL_PEER_W-1:0]          bell_peer,
    output logic [BELL_VEC_W-1:0]           bell_vector,
    output logic                            legacy_irq,
    output logic [NUM_VECS-1:0]             msg_irq,
    output logic [NUM_VECS-1:0]             msg_pending
);

    logic             wr_en;
    logic             rd_en;
    reg_sel_e         wr_sel;
    reg_sel_e         rd_sel;
    logic             legacy_hit;
    logic             route_on;
    logic [REG_W-1:0] mask_q;
    logic [REG_W-1:0] stat_q;
    bell_word_t       bell_word;

    assign wr_en      = req_valid && req_write;
    assign rd_en      = req_valid && !req_write;
    assign wr_sel     = decode_off(write_offset(req_addr));
    assign rd_sel     = decode_off(req_addr);
    assign bell_word  = bell_word_t'(req_wdata);
    assign legacy_hit = !msg_mode && (|local_event);
    assign route_on   = msg_mode && msg_enable;

    ivdb_regfile u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wdata      (req_wdata),
        .rd_en      (rd_en),
        .rd_sel     (rd_sel),
        .own_id     (own_id),
        .legacy_hit (legacy_hit),
        .mask_q     (mask_q),
        .stat_q     (stat_q),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata)
    );

    ivdb_doorbell #(.NUM_PEERS(NUM_PEERS)) u_bell (
        .clk             (clk),
        .rst             (rst),
        .bell_wr         (wr_en && wr_sel == SEL_BELL),
        .bell_word       (bell_word),
        .peer_count      (peer_count),
        .peer_vec_counts (peer_vec_counts),
        .fire_q          (bell_fire),
        .peer_q          (bell_peer),
        .vector_q        (bell_vector)
    );

    genvar gv;
    generate
        for (gv = 0; gv < NUM_VECS; gv++) begin : g_vec
            ivdb_vec_slot u_slot (
                .clk      (clk),
                .rst      (rst),
                .evt      (local_event[gv]),
                .masked   (vec_mask[gv]),
                .route_on (route_on),
                .irq_q    (msg_irq[gv]),
                .pend_q   (msg_pending[gv])
            );
        end
    endgenerate

    assign legacy_irq = |(stat_q & mask_q);

    AST_NO_IRQ_IN_LEGACY: assert property (@(posedge clk) disable iff (rst)
        !msg_mode |=> (msg_irq == '0)); // R13

    AST_MSG_LEAVES_STATUS: assert property (@(posedge clk) disable iff (rst)
        (msg_mode && !req_valid) |=> $stable(stat_q)); // R13

endmodule

// File: tb/peer_doorbell_regs_tb.sv
module peer_doorbell_regs_tb;

    localparam int NP = 4;
    localparam int NV = 4;
    localparam logic [15:0] MY_ID = 16'h0002;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [7:0]    req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          rsp_valid;
    logic [31:0]   rsp_rdata;
    logic [15:0]   peer_count = 16'd3;
    // peer0:2 vectors, peer1:1, peer2:4, peer3:5 (peer3 beyond peer_count)
    logic [NP*8-1:0] peer_vec_counts = {8'd5, 8'd4, 8'd1, 8'd2};
    logic          msg_mode = 1'b0;
    logic          msg_enable = 1'b0;
    logic [NV-1:0] vec_mask = '0;
    logic [NV-1:0] local_event = '0;
    logic          bell_fire;
    logic [15:0]   bell_peer;
    logic [7:0]    bell_vector;
    logic          legacy_irq;
    logic [NV-1:0] msg_irq;
    logic [NV-1:0] msg_pending;

    int errs = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    peer_doorbell_regs #(.NUM_PEERS(NP), .NUM_VECS(NV)) u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .own_id(MY_ID), .peer_count(peer_count), .peer_vec_counts(peer_vec_counts),
        .msg_mode(msg_mode), .msg_enable(msg_enable), .vec_mask(vec_mask),
        .local_event(local_event), .bell_fire(bell_fire), .bell_peer(bell_peer),
        .bell_vector(bell_vector), .legacy_irq(legacy_irq), .msg_irq(msg_irq),
        .msg_pending(msg_pending)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // One access; returns at the falling edge after the capturing edge.
    task automatic bus(input logic wr, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic evt(input logic [NV-1:0] v);
        @(negedge clk);
        local_event = v;
        @(negedge clk);
        local_event = '0;
    endtask

    // {write, addr, data-or-expected, requirement number}
    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [7:0]  req;
    } vec_t;

    localparam int NTAB = 15;
    localparam vec_t TAB [NTAB] = '{
        '{1'b0, 8'h00, 32'h0000_0000, 8'd1},   // R1 mask after reset
        '{1'b0, 8'h04, 32'h0000_0000, 8'd1},   // R1 status after reset
        '{1'b0, 8'h08, 32'h0000_0002, 8'd3},   // R3 identifier
        '{1'b1, 8'h00, 32'hDEAD_BEEF, 8'd2},
        '{1'b0, 8'h00, 32'hDEAD_BEEF, 8'd2},   // R2 full mask
        '{1'b1, 8'h05, 32'h1234_5678, 8'd2},   // masked to status
        '{1'b0, 8'h04, 32'h1234_5678, 8'd2},   // R2 via 0x05
        '{1'b0, 8'h04, 32'h0000_0000, 8'd4},   // R4 cleared by read
        '{1'b1, 8'h10, 32'hFFFF_FFFF, 8'd14},
        '{1'b1, 8'h08, 32'hFFFF_FFFF, 8'd14},
        '{1'b0, 8'h00, 32'hDEAD_BEEF, 8'd14},  // R14 mask untouched
        '{1'b0, 8'h08, 32'h0000_0002, 8'd14},  // R14 id untouched
        '{1'b0, 8'h0C, 32'h0000_0000, 8'd3},   // R3 doorbell reads zero
        '{1'b0, 8'h01, 32'h0000_0000, 8'd3},   // R3 unaligned read
        '{1'b0, 8'hFC, 32'h0000_0000, 8'd3}    // R3 undecoded read
    };

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 bell_fire", 32'(bell_fire), 32'd0);
        chk("R1 legacy_irq", 32'(legacy_irq), 32'd0);
        chk("R1 msg_pending", 32'(msg_pending), 32'd0);
        chk("R1 msg_irq", 32'(msg_irq), 32'd0);

        for (int i = 0; i < NTAB; i++) begin
            bus(TAB[i].wr, TAB[i].addr, TAB[i].data);
            if (!TAB[i].wr) begin
                chk($sformatf("R%0d rsp_valid entry %0d", TAB[i].req, i), 32'(rsp_valid), 32'd1);
                chk($sformatf("R%0d rdata entry %0d", TAB[i].req, i), rsp_rdata, TAB[i].data);
            end else begin
                chk($sformatf("R5 no fire entry %0d", i), 32'(bell_fire), 32'd0);
            end
        end

        // Doorbell: peer 2 vector 3, junk in bits 15:8
        bus(1'b1, 8'h0C, 32'h0002_FF03);
        chk("R5 fire", 32'(bell_fire), 32'd1);
        chk("R5 peer", 32'(bell_peer), 32'd2);
        chk("R5 vector", 32'(bell_vector), 32'd3);
        @(negedge clk);
        chk("R5 one cycle", 32'(bell_fire), 32'd0);
        bus(1'b1, 8'h0C, 32'h0003_0000);       // peer 3 not below peer_count
        chk("R6 drop peer3", 32'(bell_fire), 32'd0);
        bus(1'b1, 8'h0C, 32'h0009_0000);       // beyond table
        chk("R6 drop peer9", 32'(bell_fire), 32'd0);
        bus(1'b1, 8'h0C, 32'h0001_0001);       // peer1 has 1 vector
        chk("R7 drop p1v1", 32'(bell_fire), 32'd0);
        bus(1'b1, 8'h0C, 32'h0000_0002);       // peer0 has 2 vectors
        chk("R7 drop p0v2", 32'(bell_fire), 32'd0);
        bus(1'b1, 8'h0E, 32'h0000_0001);       // 0x0E masks to doorbell
        chk("R5 p0v1 fire", 32'(bell_fire), 32'd1);
        chk("R5 p0v1 vector", 32'(bell_vector), 32'd1);

        // Legacy mode
        evt(4'b0100);
        chk("R9 line high", 32'(legacy_irq), 32'd1);
        bus(1'b1, 8'h00, 32'hFFFF_FFFE);
        chk("R9 line low after mask", 32'(legacy_irq), 32'd0);
        bus(1'b0, 8'h04, 32'h0);
        chk("R8 status is 1", rsp_rdata, 32'd1);

        // Collision: status read and event on the same edge
        bus(1'b1, 8'h04, 32'h0000_00A5);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h04; local_event = 4'b0001;
        @(negedge clk);
        req_valid = 1'b0; local_event = '0;
        chk("R4 old value on collision", rsp_rdata, 32'h0000_00A5);
        bus(1'b0, 8'h04, 32'h0);
        chk("R8 event beats read-clear", rsp_rdata, 32'd1);

        // Collision: status write and event on the same edge
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h04; req_wdata = 32'h55;
        local_event = 4'b1000;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; local_event = '0;
        bus(1'b0, 8'h04, 32'h0);
        chk("R8 event beats write", rsp_rdata, 32'd1);

        // Message-interrupt mode
        msg_mode = 1'b1; msg_enable = 1'b1; vec_mask = '0;
        evt(4'b0010);
        chk("R10 irq", 32'(msg_irq), 32'b0010);
        chk("R10 no pending", 32'(msg_pending), 32'd0);
        @(negedge clk);
        chk("R10 one pulse", 32'(msg_irq), 32'd0);

        vec_mask = 4'b0100;
        evt(4'b0100);
        chk("R11 no irq", 32'(msg_irq), 32'd0);
        chk("R11 pending", 32'(msg_pending), 32'b0100);
        @(negedge clk);
        vec_mask = '0;
        @(negedge clk);
        chk("R12 irq on unmask", 32'(msg_irq), 32'b0100);
        chk("R12 pending cleared", 32'(msg_pending), 32'd0);
        @(negedge clk);
        chk("R12 single pulse", 32'(msg_irq), 32'd0);

        msg_enable = 1'b0;
        evt(4'b0001);
        chk("R13 no irq", 32'(msg_irq), 32'd0);
        vec_mask = 4'b0001;
        evt(4'b0001);
        chk("R13 no pending", 32'(msg_pending), 32'd0);
        bus(1'b0, 8'h04, 32'h0);
        chk("R13 status untouched", rsp_rdata, 32'd0);

        // Reset mid-run clears registers
        bus(1'b1, 8'h00, 32'h0000_FFFF);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        bus(1'b0, 8'h00, 32'h0);
        chk("R1 mask after second reset", rsp_rdata, 32'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule